// File: doc/BRIEF.md
# Single-Channel DMA Enable and Sequencing Controller

This block runs one DMA channel. Software programs four registers through a simple write port:
- a 24-bit control word;
- a block length;
- a source base address;
- a destination base address.

The control word's enable bit and its transfer-mode field decide when words move. Each word is fetched over a source-read handshake and delivered over a destination-write handshake. Addresses start at the programmed bases and step by one per word.

The transfer mode decides how much moves per trigger:
- a single word per request;
- a fixed-length line per request;
- a whole block per request;
- a whole block started by the act of enabling the channel.

The upper half of the mode encodings repeats the same four behaviours, but those modes leave the enable bit set when a block finishes. The lower half clears it. Software may clear the enable bit at any time. The channel never abandons a word it has begun fetching: that word is written to its destination before the channel goes idle.

At every block end the block pulses `done`. It also pulses `irq` in the same cycle if the interrupt-enable bit is set. A request input is sampled only while the channel is idle and enabled. Requests at other times are dropped, not queued.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, `ctrl_q` is zero, `busy`, `rd_valid`, `wr_valid`, `done` and `irq` are low.
- R2: A write with `cfg_sel`=0 stores all 24 bits of `cfg_wdata` into the control word, visible on `ctrl_q` the next cycle. Field positions are: bit 23 enable, bit 22 interrupt enable, bits 21:19 transfer mode. Bits 18:0 are held but do not change sequencing.
- R3: `rd_valid` stays high with stable `rd_addr` until `rd_ready`. `wr_valid` stays high with stable `wr_addr` and `wr_data` until `wr_ready`. A word's `wr_data` is the `rd_data` seen at its read handshake. The n-th word of a block (n from 0) uses source base+n and destination base+n.
- R4: Mode bits[20:19]=11 starts one block of (count+1) words when the enable bit goes from 0 to 1, with no request. Requests are ignored in this mode.
- R5: Mode bits[20:19]=01 moves one word per request. Mode 10 moves a line of LINE_WORDS words per request, or fewer if the block ends first. Mode 00 moves the whole remaining block per request.
- R6: When mode bit 21 is 0, the enable bit clears by itself in the cycle after the last word of a block is written. A control write in that same cycle takes precedence.
- R7: When mode bit 21 is 1, the enable bit stays set at block end. The next block starts again from the base addresses with a fresh count. The enable-triggered mode does not restart until enable is cleared and set again.
- R8: `done` pulses for one cycle after the last write handshake of a block. `irq` pulses in that same cycle only when bit 22 is set.
- R9: A request is ignored while the enable bit is clear, while a transfer is in progress, and in the cycle the channel takes up a fresh enable.
- R10: If software clears the enable bit after a word's read has been issued, exactly that word is still written. No further read is issued, and `busy` falls after that write handshake.
- R11: `cfg_sel`=1 sets the block length as N-1; `cfg_sel`=2 and 3 set the source and destination bases. These values are taken up when enable rises from 0 to 1 and again at every block end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 count, 2 source base, 3 destination base |
| cfg_wdata | input | 24 | Register write data |
| ctrl_q | output | 24 | Current control word |
| dev_req | input | 1 | Transfer request from the peripheral |
| rd_valid | output | 1 | Source read request valid |
| rd_ready | input | 1 | Source accepts the read; `rd_data` is valid in this cycle |
| rd_addr | output | ADDR_W | Source word address |
| rd_data | input | DATA_W | Source word |
| wr_valid | output | 1 | Destination write valid |
| wr_ready | input | 1 | Destination accepts the write |
| wr_addr | output | ADDR_W | Destination word address |
| wr_data | output | DATA_W | Destination word |
| busy | output | 1 | A transfer unit is in progress |
| done | output | 1 | One-cycle block-end pulse |
| irq | output | 1 | One-cycle interrupt pulse at block end |

## Verification
On every cycle, the assertions check four properties:
- the source and destination handshakes hold still under back-pressure;
- `done` is a single-cycle pulse and `irq` never appears without it;
- a disabled idle channel never leaves idle;
- a cleared enable stops the channel right after the in-flight write.

The block-completion and auto-clear relation is also checked every cycle. Word counts per trigger in each mode, base reload across blocks, and dropped requests need chosen stimulus: only the bench scenarios show them, checked against a cycle-by-cycle reference model. The graceful stop is shown by holding off the destination, clearing enable mid-word, and counting exactly one further write.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int CTRL_W  = 24;
  localparam int EN_BIT  = 23;
  localparam int IE_BIT  = 22;
  localparam int KEEP_BIT = 21;
  localparam int KIND_LO = 19;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RD   = 2'd1,
    SEQ_WR   = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    K_BLOCK_REQ = 2'b00,
    K_WORD_REQ  = 2'b01,
    K_LINE_REQ  = 2'b10,
    K_BLOCK_EN  = 2'b11
  } xfer_kind_t;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_SRC   = 2'd2,
    SEL_DST   = 2'd3
  } cfg_sel_t;

  typedef struct packed {
    logic       en;
    logic       ie;
    logic       keep;
    xfer_kind_t kind;
  } ctrl_view_t;

  function automatic ctrl_view_t decode_ctrl(input logic [CTRL_W-1:0] c);
    ctrl_view_t v;
    v.en   = c[EN_BIT];
    v.ie   = c[IE_BIT];
    v.keep = c[KEEP_BIT];
    v.kind = xfer_kind_t'(c[KIND_LO+1:KIND_LO]);
    return v;
  endfunction
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              hw_clr_en,
  input  logic              arm_take,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [ADDR_W-1:0] src_base,
  output logic [ADDR_W-1:0] dst_base,
  output logic              arm_q,
  output logic              en_live
);
  cfg_sel_t sel_e;
  logic     ctrl_wr;
  logic     rise_wr;

  assign sel_e   = cfg_sel_t'(sel);
  assign ctrl_wr = wr_en && (sel_e == SEL_CTRL);
  assign rise_wr = ctrl_wr && wdata[EN_BIT] && !ctrl_q[EN_BIT];
  // enable as seen by the sequencer: a clearing write acts at once
  assign en_live = ctrl_q[EN_BIT] && !(ctrl_wr && !wdata[EN_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      cnt_q    <= '0;
      src_base <= '0;
      dst_base <= '0;
      arm_q    <= 1'b0;
    end else begin
      if (ctrl_wr)        ctrl_q <= wdata;
      else if (hw_clr_en) ctrl_q[EN_BIT] <= 1'b0;
      if (wr_en && sel_e == SEL_COUNT) cnt_q    <= wdata[CNT_W-1:0];
      if (wr_en && sel_e == SEL_SRC)   src_base <= wdata[ADDR_W-1:0];
      if (wr_en && sel_e == SEL_DST)   dst_base <= wdata[ADDR_W-1:0];
      if (rise_wr)       arm_q <= 1'b1;
      else if (arm_take) arm_q <= 1'b0;
    end
  end

  assert_arm_on_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rise_wr |=> arm_q);
  assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_q == $past(wdata));
endmodule

// File: rtl/dma_addr_count.sv
module dma_addr_count #(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              start,
  input  logic              step,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              last_word,
  output logic              last_in_line
);
  localparam int LINE_CW = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q   <= '0;
      src_addr <= '0;
      dst_addr <= '0;
    end else if (load) begin
      left_q   <= cnt_q;
      src_addr <= src_base;
      dst_addr <= dst_base;
    end else if (step) begin
      left_q   <= left_q - 1'b1;
      src_addr <= src_addr + 1'b1;
      dst_addr <= dst_addr + 1'b1;
    end
  end

  assign last_word = (left_q == '0);

  generate
    if (LINE_WORDS > 1) begin : g_line
      logic [LINE_CW-1:0] pos_q;
      always_ff @(posedge clk) begin
        if (!rst_n || start) pos_q <= '0;
        else if (step) begin
          if (pos_q == LINE_CW'(LINE_WORDS - 1)) pos_q <= '0;
          else                                  pos_q <= pos_q + 1'b1;
        end
      end
      assign last_in_line = (pos_q == LINE_CW'(LINE_WORDS - 1));
    end else begin : g_noline
      assign last_in_line = 1'b1;
    end
  endgenerate

  assert_end_reloads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_word) |-> load);
endmodule

// File: rtl/dma_word_seq.sv
module dma_word_seq
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_view_t        cv,
  input  logic              en_live,
  input  logic              arm,
  input  logic              req,
  input  logic              last_word,
  input  logic              last_in_line,
  input  logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wr_ready,
  output logic              rd_valid,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data,
  output logic              load,
  output logic              start,
  output logic              step,
  output logic              arm_take,
  output logic              hw_clr_en,
  output logic              busy,
  output logic              done,
  output logic              irq
);
  seq_state_t state_q, state_d;
  logic       blk_end;
  logic       unit_end;

  assign step     = (state_q == SEQ_WR) && wr_ready;
  assign blk_end  = step && last_word;
  assign unit_end = blk_end || (cv.kind == K_WORD_REQ) ||
                    ((cv.kind == K_LINE_REQ) && last_in_line);

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    start     = 1'b0;
    arm_take  = 1'b0;
    hw_clr_en = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (arm) begin
          arm_take = 1'b1;
          load     = 1'b1;
          if (cv.kind == K_BLOCK_EN && cv.en) begin
            state_d = SEQ_RD;
            start   = 1'b1;
          end
        end else if (cv.en && req && cv.kind != K_BLOCK_EN) begin
          state_d = SEQ_RD;
          start   = 1'b1;
        end
      end
      SEQ_RD: if (rd_ready) state_d = SEQ_WR;
      SEQ_WR: begin
        if (wr_ready) begin
          if (blk_end) begin
            load      = 1'b1;
            hw_clr_en = !cv.keep;
          end
          state_d = (unit_end || !en_live) ? SEQ_IDLE : SEQ_RD;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      wr_data <= '0;
      done    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == SEQ_RD && rd_ready) wr_data <= rd_data;
      done <= blk_end;
      irq  <= blk_end && cv.ie;
    end
  end

  assign rd_valid = (state_q == SEQ_RD);
  assign wr_valid = (state_q == SEQ_WR);
  assign busy     = (state_q != SEQ_IDLE);

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid);
  assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));
  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE && !cv.en) |=> !busy);
  assert_graceful_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !en_live) |=> (!rd_valid && !wr_valid));
  assert_irq_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [23:0]       cfg_wdata,
  output logic [23:0]       ctrl_q,
  input  logic              dev_req,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              irq
);
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] src_base, dst_base;
  logic              arm_q, en_live, arm_take, hw_clr_en;
  logic              load, start, step, last_word, last_in_line;
  ctrl_view_t        cv;

  assign cv = decode_ctrl(ctrl_q);

  dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .hw_clr_en(hw_clr_en), .arm_take(arm_take), .ctrl_q(ctrl_q), .cnt_q(cnt_q),
    .src_base(src_base), .dst_base(dst_base), .arm_q(arm_q), .en_live(en_live)
  );

  dma_addr_count #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_WORDS(LINE_WORDS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .start(start), .step(step),
    .cnt_q(cnt_q), .src_base(src_base), .dst_base(dst_base),
    .src_addr(rd_addr), .dst_addr(wr_addr),
    .last_word(last_word), .last_in_line(last_in_line)
  );

  dma_word_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cv(cv), .en_live(en_live), .arm(arm_q),
    .req(dev_req), .last_word(last_word), .last_in_line(last_in_line),
    .rd_ready(rd_ready), .rd_data(rd_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .wr_valid(wr_valid), .wr_data(wr_data),
    .load(load), .start(start), .step(step), .arm_take(arm_take),
    .hw_clr_en(hw_clr_en), .busy(busy), .done(done), .irq(irq)
  );

  assert_rd_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> $stable(rd_addr));
  assert_wr_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(wr_addr));
  assert_autoclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(ctrl_q[KEEP_BIT]) && !$past(cfg_wr && cfg_sel == 2'd0))
      |-> !ctrl_q[EN_BIT]);
endmodule

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
  localparam int AW = 16, DW = 24, CW = 16, LW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_sel = 2'd0;
  logic [23:0]   cfg_wdata = '0;
  logic [23:0]   ctrl_q;
  logic          dev_req = 1'b0;
  logic          rd_valid, rd_ready, wr_valid, wr_ready, busy, done, irq;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;

  function automatic logic [23:0] src_word(input int a);
    return 24'((a * 37) ^ 24'h5A3C11);
  endfunction
  assign rd_data = src_word(int'(rd_addr));

  dma_chan_ctrl #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW), .LINE_WORDS(LW)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ready generation
  bit bp_on = 0, hold_wr = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_ready = bp_on ? lfsr[3] : 1'b1;
    wr_ready = hold_wr ? 1'b0 : (bp_on ? lfsr[7] : 1'b1);
  end
  initial begin rd_ready = 1'b1; wr_ready = 1'b1; end

  // reference model
  int m_st, m_cnt, m_sb, m_db, m_left, m_sa, m_da, m_line, m_kind, m_nst;
  logic [23:0] m_ctrl, m_data;
  bit m_arm, m_done, m_irq, m_en, m_live, m_reload, m_aclr, m_last, m_unit;
  int n_wr = 0, n_done = 0, n_irq = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_sb = 0; m_db = 0; m_left = 0; m_sa = 0; m_da = 0;
      m_line = 0; m_ctrl = '0; m_data = '0; m_arm = 0; m_done = 0; m_irq = 0;
    end else begin
      if (wr_valid && wr_ready) n_wr++;
      if (done) n_done++;
      if (irq) n_irq++;
      m_en = m_ctrl[23]; m_kind = int'(m_ctrl[20:19]);
      m_live = m_en && !(cfg_wr && cfg_sel == 2'd0 && !cfg_wdata[23]);
      m_reload = 0; m_aclr = 0; m_nst = m_st; m_done = 0; m_irq = 0;
      if (m_st == 0) begin
        if (m_arm) begin
          m_reload = 1; m_arm = 0;
          if (m_kind == 3 && m_en) begin m_nst = 1; m_line = 0; end
        end else if (m_en && dev_req && m_kind != 3) begin
          m_nst = 1; m_line = 0;
        end
      end else if (m_st == 1) begin
        if (rd_ready) begin m_data = src_word(m_sa); m_nst = 2; end
      end else if (wr_ready) begin
        m_last = (m_left == 0);
        m_unit = m_last || m_kind == 1 || (m_kind == 2 && m_line == LW - 1);
        if (m_last) begin
          m_done = 1; m_irq = m_ctrl[22]; m_reload = 1; m_aclr = !m_ctrl[21];
        end else begin
          m_left--; m_sa = (m_sa + 1) & 16'hFFFF; m_da = (m_da + 1) & 16'hFFFF;
        end
        m_line = (m_line + 1) % LW;
        m_nst = (m_unit || !m_live) ? 0 : 1;
      end
      if (m_reload) begin m_left = m_cnt; m_sa = m_sb; m_da = m_db; end
      if (cfg_wr && cfg_sel == 2'd0) begin
        if (cfg_wdata[23] && !m_ctrl[23]) m_arm = 1;
        m_ctrl = cfg_wdata;
      end else if (m_aclr) m_ctrl[23] = 1'b0;
      if (cfg_wr && cfg_sel == 2'd1) m_cnt = int'(cfg_wdata[CW-1:0]);
      if (cfg_wr && cfg_sel == 2'd2) m_sb = int'(cfg_wdata[AW-1:0]);
      if (cfg_wr && cfg_sel == 2'd3) m_db = int'(cfg_wdata[AW-1:0]);
      m_st = m_nst;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 ctrl_q vs model", ctrl_q, m_ctrl);
      check("R3 rd_valid vs model", rd_valid, m_st == 1);
      check("R3 wr_valid vs model", wr_valid, m_st == 2);
      check("R5 busy vs model", busy, m_st != 0);
      if (rd_valid) check("R3 rd_addr vs model", rd_addr, m_sa);
      if (wr_valid) begin
        check("R3 wr_addr vs model", wr_addr, m_da);
        check("R3 wr_data vs model", wr_data, m_data);
      end
      check("R8 done vs model", done, m_done);
      check("R8 irq vs model", irq, m_irq);
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic cfg(input logic [1:0] s, input logic [23:0] d);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d; tick(); cfg_wr = 1'b0;
  endtask
  task automatic pulse_req(); dev_req = 1'b1; tick(); dev_req = 1'b0; endtask
  task automatic settle();
    repeat (3) tick();
    for (int i = 0; i < 3000 && busy; i++) tick();
    tick();
  endtask
  function automatic logic [23:0] mk(input bit en, input bit ie, input logic [2:0] md);
    return {en, ie, md, 19'h0};
  endfunction

  bit finished = 0;
  int b_wr, b_done, b_irq;

  initial begin
    repeat (3) tick();
    // R1 reset values
    check("R1 ctrl_q at reset", ctrl_q, 0);
    check("R1 busy at reset", busy, 0);
    check("R1 valids at reset", {rd_valid, wr_valid}, 0);
    check("R1 done/irq at reset", {done, irq}, 0);
    rst_n = 1'b1; tick();

    // R2 readback, R9 request while disabled
    cfg(2'd0, 24'h5ABCDE); tick();
    check("R2 readback", ctrl_q, 24'h5ABCDE);
    b_wr = n_wr; pulse_req(); repeat (4) tick();
    check("R9 req while disabled", n_wr - b_wr, 0);
    check("R9 busy while disabled", busy, 0);
    cfg(2'd0, 24'h0);

    // R4 R6 R8 R11 enable-triggered block with auto-clear
    cfg(2'd1, 24'd3); cfg(2'd2, 24'h100); cfg(2'd3, 24'h200);
    b_wr = n_wr; b_done = n_done; b_irq = n_irq;
    cfg(2'd0, mk(1, 1, 3'b011)); settle();
    check("R4 block words", n_wr - b_wr, 4);
    check("R8 done count", n_done - b_done, 1);
    check("R8 irq count with ie", n_irq - b_irq, 1);
    check("R6 enable auto-cleared", ctrl_q[23], 0);

    // R7 keep-enable block, no restart, requests ignored
    b_wr = n_wr; b_done = n_done; b_irq = n_irq;
    cfg(2'd0, mk(1, 0, 3'b111)); settle();
    check("R7 keep block words", n_wr - b_wr, 4);
    check("R7 enable kept", ctrl_q[23], 1);
    check("R8 no irq without ie", n_irq - b_irq, 0);
    b_wr = n_wr; pulse_req(); repeat (20) tick();
    check("R7 no restart / R4 req ignored", n_wr - b_wr, 0);
    cfg(2'd0, 24'h0);

    // R5 word per request, R9 request while busy
    bp_on = 1;
    cfg(2'd1, 24'd2); cfg(2'd0, mk(1, 0, 3'b001)); repeat (3) tick();
    b_wr = n_wr; pulse_req(); settle();
    check("R5 one word per req", n_wr - b_wr, 1);
    b_wr = n_wr; pulse_req(); pulse_req(); settle();
    check("R9 req while busy ignored", n_wr - b_wr, 1);
    b_done = n_done; pulse_req(); settle();
    check("R6 word mode end clears", ctrl_q[23], 0);
    check("R8 word mode done", n_done - b_done, 1);

    // R5 line per request
    cfg(2'd1, 24'd7); cfg(2'd0, mk(1, 1, 3'b010)); repeat (3) tick();
    b_wr = n_wr; pulse_req(); settle();
    check("R5 line words", n_wr - b_wr, LW);
    b_irq = n_irq; pulse_req(); settle();
    check("R5 second line words", n_wr - b_wr, 2 * LW);
    check("R8 line irq", n_irq - b_irq, 1);
    check("R6 line clears", ctrl_q[23], 0);

    // R5 block per request without auto-clear, R7 reload from base
    cfg(2'd1, 24'd4); cfg(2'd2, 24'h40); cfg(2'd0, mk(1, 0, 3'b100)); repeat (3) tick();
    b_wr = n_wr; pulse_req(); settle();
    check("R5 block per req", n_wr - b_wr, 5);
    pulse_req(); settle();
    check("R7 second block", n_wr - b_wr, 10);
    check("R7 enable kept block mode", ctrl_q[23], 1);
    cfg(2'd0, 24'h0);
    bp_on = 0;

    // R10 graceful stop
    cfg(2'd1, 24'd15); hold_wr = 1;
    cfg(2'd0, mk(1, 0, 3'b011));
    for (int i = 0; i < 50 && !wr_valid; i++) tick();
    check("R10 word in flight", wr_valid, 1);
    b_wr = n_wr; b_done = n_done;
    cfg(2'd0, mk(0, 0, 3'b011)); repeat (5) tick();
    hold_wr = 0; settle(); repeat (5) tick();
    check("R10 exactly one more write", n_wr - b_wr, 1);
    check("R10 stopped", busy, 0);
    check("R10 no block end", n_done - b_done, 0);
    // R11 re-enable reloads count and base
    b_wr = n_wr; cfg(2'd0, mk(1, 0, 3'b011)); settle();
    check("R11 full block after re-arm", n_wr - b_wr, 16);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule